// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Leading-Zero Blanking

This block takes an eight-digit BCD word that is already held stable elsewhere and time-shares it onto one four-bit BCD bus. One of eight strobes is active at a time, and each strobe marks the digit that is on the bus. The scan starts at the most significant digit, walks down to the least significant one, and then starts again. A slow external scan clock paces the scan. That clock is not a system clock: the block samples it on the system clock and moves one digit on each of its falling edges.

A blank output lets a display driver hide leading zeros. The blanking state is armed again at the start of every most significant digit time. It is cleared by three things: the first nonzero digit, a decimal-point input that is raised while a digit is being shown, or a high overflow flag. Once cleared, it stays clear for the rest of that scan. The least significant digit is never blanked, so a zero value shows as a single 0.

A scan-reset input holds the scan at the most significant digit. Its release is synchronized to the system clock, so scanning restarts cleanly no matter when the release happens relative to the scan clock.

Top module: `digscan_top`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, strobe_o equals 8'h80 (most significant digit selected) and the blanking state is armed.
- R2: Exactly one strobe bit is high at all times. strobe_o changes only in response to a falling edge of scan_clk_i, and appears within four system clocks of that edge. A rising edge, or a scan clock held at one level, leaves strobe_o unchanged.
- R3: Each falling scan-clock edge moves the active strobe from bit k to bit k-1. From bit 0 it wraps to bit 7.
- R4: While scan_rst_i is high, strobe_o is held at 8'h80 and scan-clock edges are ignored. After release, the first falling edge selects bit 6.
- R5: bcd_o equals bcd_word_i[4k+3:4k], where k is the index of the active strobe bit. Bit 7 is the most significant digit.
- R6: With dp_i and ovf_i low, blank_o is high during digit k exactly when digit k and every more significant digit are zero.
- R7: blank_o is never high while strobe bit 0 is active.
- R8: If dp_i is high while digit k is shown, that digit and every less significant digit in the same scan are not blanked.
- R9: While ovf_i is high, blank_o is low.
- R10: When the scan wraps from bit 0 to bit 7, blanking is armed again. A zero most significant digit is then blanked even if the previous scan cleared the blanking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk_i | input | 1 | Scan pacing clock, asynchronous, sampled; the scan advances on its falling edge |
| scan_rst_i | input | 1 | Holds the scan at the most significant digit while high |
| dp_i | input | 1 | Decimal point for the digit now being shown |
| ovf_i | input | 1 | Overflow flag; forces the display unblanked |
| bcd_word_i | input | 32 | Held BCD word, nibble k is digit k |
| bcd_o | output | 4 | BCD value of the selected digit |
| strobe_o | output | 8 | One-hot digit strobes, bit 7 = most significant |
| blank_o | output | 1 | High when the current digit is a suppressed leading zero |

## Verification
Two events can fall in the same cycle. One is a scan advance that wraps from the least to the most significant digit and must re-arm blanking. The other is a clear condition: the least significant digit, a raised decimal point, or a high overflow flag. The set has to win for the next scan. The bench provokes this by finishing scans in which blanking was cleared early by the decimal point, by a nonzero digit, or with overflow still high. It then checks blank_o at the first most significant digit after the wrap against the expected mask. A second collision is tested by sending scan-clock edges while scan reset is held, and checking that the strobe stays on the most significant digit and first moves only after the release.

// File: rtl/digscan_pkg.sv
package digscan_pkg;

    localparam int unsigned DIGITS_DEF  = 8;
    localparam int unsigned NIB_W_DEF   = 4;
    localparam int unsigned SYNC_DEF    = 2;

    typedef struct packed {
        logic [NIB_W_DEF-1:0] value;
        logic                 is_last;
    } digit_view_t;

    typedef struct packed {
        logic adv;
        logic hold;
    } scan_evt_t;

    function automatic logic nib_nonzero(input logic [NIB_W_DEF-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/digscan_sync.sv
module digscan_sync
    import digscan_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scan_clk_i,
    input  logic      scan_rst_i,
    output scan_evt_t evt_o
);
    localparam int unsigned TOP = STAGES;

    logic [TOP:0]      clk_chain;
    logic [STAGES-1:0] rst_chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_chain <= '0;
            rst_chain <= '1;
        end else begin
            clk_chain <= {clk_chain[TOP-1:0], scan_clk_i};
            rst_chain <= {rst_chain[STAGES-2:0], scan_rst_i};
        end
    end

    always_comb begin
        evt_o.hold = rst_chain[STAGES-1];
        evt_o.adv  = clk_chain[TOP] & ~clk_chain[TOP-1] & ~rst_chain[STAGES-1];
    end

endmodule

// File: rtl/digscan_ring.sv
module digscan_ring
    import digscan_pkg::*;
#(
    parameter int unsigned DIGITS = DIGITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_evt_t         evt_i,
    output logic [DIGITS-1:0] strobe_o,
    output logic              wrap_o
);
    localparam logic [DIGITS-1:0] FIRST = {1'b1, {(DIGITS-1){1'b0}}};

    logic [DIGITS-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (rst || evt_i.hold) begin
            ring_q <= FIRST;
        end else if (evt_i.adv) begin
            ring_q <= {ring_q[0], ring_q[DIGITS-1:1]};
        end
    end

    assign strobe_o = ring_q;
    assign wrap_o   = evt_i.adv & ring_q[0];

endmodule

// File: rtl/digscan_mux.sv
module digscan_mux
    import digscan_pkg::*;
#(
    parameter int unsigned DIGITS = DIGITS_DEF,
    parameter int unsigned NIB_W  = NIB_W_DEF
) (
    input  logic [DIGITS*NIB_W-1:0] word_i,
    input  logic [DIGITS-1:0]       strobe_i,
    output digit_view_t             view_o
);
    logic [DIGITS-1:0][NIB_W-1:0] masked;

    for (genvar k = 0; k < DIGITS; k++) begin : g_sel
        assign masked[k] = strobe_i[k] ? word_i[k*NIB_W +: NIB_W] : '0;
    end

    always_comb begin
        view_o.value = '0;
        for (int k = 0; k < DIGITS; k++) begin
            view_o.value = view_o.value | masked[k];
        end
        view_o.is_last = strobe_i[0];
    end

endmodule

// File: rtl/digscan_blank.sv
module digscan_blank
    import digscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arm_i,
    input  digit_view_t view_i,
    input  logic        dp_i,
    input  logic        ovf_i,
    output logic        blank_o
);
    logic armed_q;
    logic release_c;

    assign release_c = nib_nonzero(view_i.value) | dp_i | ovf_i | view_i.is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
        end else if (arm_i) begin
            armed_q <= 1'b1;
        end else if (release_c) begin
            armed_q <= 1'b0;
        end
    end

    assign blank_o = armed_q & ~release_c;

endmodule

// File: rtl/digscan_top.sv
module digscan_top
    import digscan_pkg::*;
#(
    parameter int unsigned DIGITS = DIGITS_DEF,
    parameter int unsigned NIB_W  = NIB_W_DEF,
    parameter int unsigned SYNC   = SYNC_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scan_clk_i,
    input  logic                    scan_rst_i,
    input  logic                    dp_i,
    input  logic                    ovf_i,
    input  logic [DIGITS*NIB_W-1:0] bcd_word_i,
    output logic [NIB_W-1:0]        bcd_o,
    output logic [DIGITS-1:0]       strobe_o,
    output logic                    blank_o
);
    scan_evt_t   evt;
    digit_view_t view;
    logic        wrap;
    logic        adv_w;
    logic        hold_w;

    digscan_sync #(.STAGES(SYNC)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scan_clk_i (scan_clk_i),
        .scan_rst_i (scan_rst_i),
        .evt_o      (evt)
    );

    digscan_ring #(.DIGITS(DIGITS)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .strobe_o (strobe_o),
        .wrap_o   (wrap)
    );

    digscan_mux #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_mux (
        .word_i   (bcd_word_i),
        .strobe_i (strobe_o),
        .view_o   (view)
    );

    digscan_blank u_blank (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (wrap | evt.hold),
        .view_i  (view),
        .dp_i    (dp_i),
        .ovf_i   (ovf_i),
        .blank_o (blank_o)
    );

    assign adv_w  = evt.adv;
    assign hold_w = evt.hold;
    assign bcd_o  = view.value;

endmodule

// File: rtl/digscan_chk.sv
module digscan_chk #(
    parameter int unsigned DIGITS = 8,
    parameter int unsigned NIB_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [DIGITS-1:0] strobe_o,
    input logic [NIB_W-1:0]  bcd_o,
    input logic              blank_o,
    input logic              ovf_i,
    input logic              adv,
    input logic              hold
);
    localparam logic [DIGITS-1:0] FIRST = {1'b1, {(DIGITS-1){1'b0}}};

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe_o) == 1);

    assert_move_only_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(strobe_o) |-> ($past(adv) || $past(hold)));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !hold && !strobe_o[0]) |=> (strobe_o == ($past(strobe_o) >> 1)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !hold && strobe_o[0]) |=> (strobe_o == FIRST));

    assert_hold_msd_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> (strobe_o == FIRST));

    assert_lsd_shown_R7: assert property (@(posedge clk) disable iff (rst)
        strobe_o[0] |-> !blank_o);

    assert_nonzero_shown_R6: assert property (@(posedge clk) disable iff (rst)
        (bcd_o != '0) |-> !blank_o);

    assert_ovf_shown_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_i |-> !blank_o);

endmodule

bind digscan_top digscan_chk #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_o (strobe_o),
    .bcd_o    (bcd_o),
    .blank_o  (blank_o),
    .ovf_i    (ovf_i),
    .adv      (adv_w),
    .hold     (hold_w)
);

// File: tb/digscan_top_test.sv
`timescale 1ns/1ps
module digscan_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_clk = 1'b0;
    logic        scan_rst = 1'b0;
    logic        dp = 1'b0;
    logic        ovf = 1'b0;
    logic [31:0] word = '0;
    logic [3:0]  bcd;
    logic [7:0]  strobe;
    logic        blank;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    digscan_top uut (
        .clk        (clk),
        .rst        (rst),
        .scan_clk_i (scan_clk),
        .scan_rst_i (scan_rst),
        .dp_i       (dp),
        .ovf_i      (ovf),
        .bcd_word_i (word),
        .bcd_o      (bcd),
        .strobe_o   (strobe),
        .blank_o    (blank)
    );

    // {word[31:0], dp digit[3:0] (8 = none), ovf, 3'b0, blank mask[7:0]}
    localparam logic [47:0] VEC [8] = '{
        {32'h0000_0000, 4'd8, 1'b0, 3'b0, 8'hFE},
        {32'h0012_3400, 4'd8, 1'b0, 3'b0, 8'hC0},
        {32'h8000_0000, 4'd8, 1'b0, 3'b0, 8'h00},
        {32'h0000_0005, 4'd8, 1'b0, 3'b0, 8'hFE},
        {32'h0000_0000, 4'd3, 1'b0, 3'b0, 8'hF0},
        {32'h0000_0000, 4'd8, 1'b1, 3'b0, 8'h00},
        {32'h0000_0700, 4'd5, 1'b0, 3'b0, 8'hC0},
        {32'h0900_0000, 4'd8, 1'b0, 3'b0, 8'h80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        scan_clk = 1'b1;
        repeat (4) @(negedge clk);
        scan_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic scan_restart();
        scan_rst = 1'b1;
        repeat (4) @(negedge clk);
        scan_rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", 32'(strobe), 32'h80);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe after reset", 32'(strobe), 32'h80);
        chk("R1 blank armed", 32'(blank), 32'h1);

        // R2: level and rising edge alone do not move the scan
        scan_clk = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 rising edge ignored", 32'(strobe), 32'h80);
        scan_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 falling edge advances", 32'(strobe), 32'h40);
        repeat (20) @(negedge clk);
        chk("R2 stable while low", 32'(strobe), 32'h40);

        // Vector walk: R3 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            logic [31:0] w;
            logic [3:0]  dpd;
            logic [7:0]  mask;
            w    = VEC[v][47:16];
            dpd  = VEC[v][15:12];
            mask = VEC[v][7:0];
            word = w;
            ovf  = VEC[v][11];
            scan_restart();
            for (int k = 7; k >= 0; k--) begin
                if (dpd == 4'(k)) dp = 1'b1;
                @(negedge clk);
                chk("R3 strobe order", 32'(strobe), 32'(8'h01 << k));
                chk("R5 bcd value", 32'(bcd), 32'(w[k*4 +: 4]));
                if (k == 0)
                    chk("R7 lsd never blank", 32'(blank), 32'(mask[0]));
                else if (dpd != 4'd8 && k <= int'(dpd))
                    chk("R8 dp unblank", 32'(blank), 32'(mask[k]));
                else if (VEC[v][11])
                    chk("R9 overflow unblank", 32'(blank), 32'(mask[k]));
                else
                    chk("R6 leading zero", 32'(blank), 32'(mask[k]));
                dp = 1'b0;
                if (k != 0) step();
            end
            step();
            chk("R3 wrap to msd", 32'(strobe), 32'h80);
            chk("R10 rearm at wrap", 32'(blank), 32'(mask[7]));
        end
        ovf = 1'b0;

        // R4: scan reset holds MSD, edges ignored, release then step
        word = 32'h1234_5678;
        scan_restart();
        step();
        step();
        chk("R4 pre hold position", 32'(strobe), 32'h20);
        scan_rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 forced msd", 32'(strobe), 32'h80);
        step();
        step();
        chk("R4 edges ignored in hold", 32'(strobe), 32'h80);
        chk("R5 bcd in hold", 32'(bcd), 32'h1);
        scan_rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 still msd after release", 32'(strobe), 32'h80);
        step();
        chk("R4 first step after release", 32'(strobe), 32'h40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule